// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit timestamps transitions on an external pin. The pin is brought into the clock domain by a short synchroniser chain, and its rising and falling transitions are detected. A mode field decides which transitions count as capture events: any edge, falling edges only, rising edges only, every 4th or every 16th rising edge, or a trigger mode that waits for one edge of a chosen polarity and then takes every edge. For each capture event, the value of one of two free-running timer inputs is pushed into a small FIFO. The value is either the full timer word or its low 16 bits, zero-extended.

Software uses a small register port. The control word can be written whole or changed atomically through clear, set and invert aliases. A read of the buffer register returns the oldest timestamp and removes it. The control word also shows a not-empty flag and an overflow flag. An interrupt pulse is raised after every 1st, 2nd, 3rd or 4th capture event, as programmed. An interrupt-only mode raises a pulse on every rising edge and stores nothing. Two control bits let an idle request input or a debug halt input suspend capture.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset, the control word reads 0x0000, `irq` is low, and a buffer read returns zero.
- R2: The control word is written at offset 0x00. A write-1-to-clear alias is at 0x04, a write-1-to-set alias at 0x08 and a write-1-to-invert alias at 0x0C. Only bits 15:13, 9:5 and 2:0 are writable. Bit 3 (not empty) and bit 4 (overflow) are read-only status.
- R3: The FIFO holds 4 entries. A capture event that arrives while the FIFO is full is dropped and sets the overflow flag (bit 4). Clearing the enable bit (bit 15) empties the FIFO and clears the overflow flag.
- R4: Mode field bits 2:0 select the capture event: 1 = every edge, 2 = every falling edge, 3 = every rising edge.
- R5: Mode 4 captures only on every 4th rising edge. Mode 5 captures only on every 16th rising edge.
- R6: In mode 6, edges are ignored until the first edge whose polarity matches bit 9 (1 = rising, 0 = falling). That edge and every later edge are captured.
- R7: In mode 7, every rising edge produces a one-cycle `irq` pulse and nothing is written to the FIFO.
- R8: Bits 6:5 (values 0 to 3) make `irq` pulse once for every 1st, 2nd, 3rd or 4th capture event.
- R9: Bit 7 selects the timer (0 = `tmr_a`, 1 = `tmr_b`). Bit 8 = 1 stores all 32 bits. Bit 8 = 0 stores the low 16 bits, zero-extended. The value stored is the timer value in the cycle in which the synchronised edge is detected.
- R10: When bit 13 is set, no capture happens while `idle_req` is high. When bit 14 is set, no capture happens while `dbg_halt` is high. With those bits clear, the two inputs have no effect.
- R11: With the enable bit clear, or with mode 0, no edge is captured.
- R12: A read at offset 0x10 returns the oldest stored timestamp and removes it. Bit 3 reads 1 exactly while at least one entry is stored.
- R13: The prescale counters, the trigger arming and the interrupt event counter restart whenever the mode field changes or the unit is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read at 0x10 pops) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data for the control word and its aliases |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 1 | Asynchronous capture pin |
| tmr_a | input | 32 | Timer input selected when bit 7 is 0 |
| tmr_b | input | 32 | Timer input selected when bit 7 is 1 |
| idle_req | input | 1 | Idle request, honoured when bit 13 is set |
| dbg_halt | input | 1 | Debug halt, honoured when bit 14 is set |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Most internal faults show up at the buffer register as a missing, extra or out-of-order timestamp. The bench drains the queue right after each stimulus group, so such a fault is seen within a few reads. A prescale counter or trigger arming flag that fails to restart shows up as a capture one or more edges too early, which the mode-change sequence exposes. A broken FIFO count or a wrong overflow flag appears in control bits 3 and 4 on the next read of the control word. A broken interrupt counter shows up as a wrong number of `irq` pulses, counted a few cycles after the last edge.

// File: rtl/esu_pkg.sv
package esu_pkg;

  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_ANY     = 3'd1,
    MD_FALL    = 3'd2,
    MD_RISE    = 3'd3,
    MD_DIV4    = 3'd4,
    MD_DIV16   = 3'd5,
    MD_ARMED   = 3'd6,
    MD_IRQONLY = 3'd7
  } esu_mode_e;

  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_CLR  = 5'h04;
  localparam logic [4:0] OFS_SET  = 5'h08;
  localparam logic [4:0] OFS_INV  = 5'h0C;
  localparam logic [4:0] OFS_BUF  = 5'h10;

  localparam int B_NE    = 3;
  localparam int B_OVF   = 4;
  localparam int B_RATE  = 5;
  localparam int B_TSEL  = 7;
  localparam int B_WIDE  = 8;
  localparam int B_FIRST = 9;
  localparam int B_IDLE  = 13;
  localparam int B_FRZ   = 14;
  localparam int B_ON    = 15;

  localparam logic [15:0] CTRL_WMASK = 16'hE3E7;

endpackage

// File: rtl/esu_pin_sync.sv
module esu_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level; sh[STAGES] is its previous value.
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/esu_event_qual.sv
module esu_event_qual import esu_pkg::*; #(
  parameter int PRE_W = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      active,
  input  esu_mode_e mode,
  input  logic      first_rise,
  input  logic      rise,
  input  logic      fall,
  output logic      restart,
  output logic      cap_evt,
  output logic      pulse_evt
);
  localparam logic [PRE_W-1:0] DIV4_LAST  = PRE_W'(3);
  localparam logic [PRE_W-1:0] DIV16_LAST = PRE_W'(15);

  esu_mode_e        mode_seen_q;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             armed_q, armed_d;

  assign restart = !en || (mode != mode_seen_q);

  always_comb begin
    pre_d     = pre_q;
    armed_d   = armed_q;
    cap_evt   = 1'b0;
    pulse_evt = 1'b0;
    if (restart) begin
      pre_d   = '0;
      armed_d = 1'b0;
    end else if (active) begin
      case (mode)
        MD_ANY:   cap_evt = rise | fall;
        MD_FALL:  cap_evt = fall;
        MD_RISE:  cap_evt = rise;
        MD_DIV4: begin
          if (rise) begin
            if (pre_q == DIV4_LAST) begin
              cap_evt = 1'b1;
              pre_d   = '0;
            end else begin
              pre_d = pre_q + PRE_W'(1);
            end
          end
        end
        MD_DIV16: begin
          if (rise) begin
            if (pre_q == DIV16_LAST) begin
              cap_evt = 1'b1;
              pre_d   = '0;
            end else begin
              pre_d = pre_q + PRE_W'(1);
            end
          end
        end
        MD_ARMED: begin
          if (armed_q) begin
            cap_evt = rise | fall;
          end else if (first_rise ? rise : fall) begin
            cap_evt = 1'b1;
            armed_d = 1'b1;
          end
        end
        MD_IRQONLY: pulse_evt = rise;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_seen_q <= MD_OFF;
      pre_q       <= '0;
      armed_q     <= 1'b0;
    end else begin
      mode_seen_q <= mode;
      pre_q       <= pre_d;
      armed_q     <= armed_d;
    end
  end
endmodule

// File: rtl/esu_irq_gen.sv
module esu_irq_gen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              cap_evt,
  input  logic              pulse_evt,
  input  logic [RATE_W-1:0] rate,
  output logic              irq
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              irq_q, irq_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = pulse_evt;
    if (restart) begin
      cnt_d = '0;
    end else if (cap_evt) begin
      if (cnt_q == rate) begin
        irq_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/esu_fifo.sv
module esu_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] fill
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             do_push, do_pop;

  assign do_push = push && (fill_q != FULL_CNT);
  assign do_pop  = pop  && (fill_q != '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (flush) begin
      wr_d   = '0;
      rd_d   = '0;
      fill_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   fill_d = fill_q + CNT_W'(1);
        2'b01:   fill_d = fill_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign empty = (fill_q == '0);
  assign full  = (fill_q == FULL_CNT);
  assign fill  = fill_q;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit import esu_pkg::*; #(
  parameter int TW     = 32,
  parameter int DEPTH  = 4,
  parameter int PRE_W  = 4,
  parameter int SYNC   = 2,
  parameter int RATE_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [4:0]    bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [TW-1:0] bus_rdata,
  input  logic          pin_in,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          idle_req,
  input  logic          dbg_halt,
  output logic          irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sh_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_ni = rst_sh_q[1];

  // Control word with write, clear, set and invert aliases.
  logic [15:0] ctrl_q, ctrl_d, wbits;
  assign wbits = bus_wdata & CTRL_WMASK;

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL: ctrl_d = wbits;
        OFS_CLR:  ctrl_d = ctrl_q & ~wbits;
        OFS_SET:  ctrl_d = ctrl_q | wbits;
        OFS_INV:  ctrl_d = ctrl_q ^ wbits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  logic      on, active;
  esu_mode_e mode;
  assign on     = ctrl_q[B_ON];
  assign mode   = esu_mode_e'(ctrl_q[2:0]);
  assign active = on && !(ctrl_q[B_IDLE] && idle_req) && !(ctrl_q[B_FRZ] && dbg_halt);

  // Pin path
  logic rise, fall;
  esu_pin_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_ni),
    .pin  (pin_in),
    .rise (rise),
    .fall (fall)
  );

  logic restart, cap_evt, pulse_evt;
  esu_event_qual #(.PRE_W(PRE_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en        (on),
    .active    (active),
    .mode      (mode),
    .first_rise(ctrl_q[B_FIRST]),
    .rise      (rise),
    .fall      (fall),
    .restart   (restart),
    .cap_evt   (cap_evt),
    .pulse_evt (pulse_evt)
  );

  esu_irq_gen #(.RATE_W(RATE_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .restart  (restart),
    .cap_evt  (cap_evt),
    .pulse_evt(pulse_evt),
    .rate     (ctrl_q[B_RATE +: RATE_W]),
    .irq      (irq)
  );

  // Timestamp selection
  logic [TW-1:0] tsel, stamp;
  assign tsel  = ctrl_q[B_TSEL] ? tmr_b : tmr_a;
  assign stamp = ctrl_q[B_WIDE] ? tsel : {{(TW-16){1'b0}}, tsel[15:0]};

  // Queue and overflow
  logic             f_empty, f_full, f_pop;
  logic [TW-1:0]    f_head;
  logic [CNT_W-1:0] fill_cnt;
  logic             ovf_q, ovf_d;

  assign f_pop = bus_rd && (bus_addr == OFS_BUF);

  esu_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_ni),
    .flush(!on),
    .push (cap_evt),
    .din  (stamp),
    .pop  (f_pop),
    .head (f_head),
    .empty(f_empty),
    .full (f_full),
    .fill (fill_cnt)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (!on)                  ovf_d = 1'b0;
    else if (cap_evt && f_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_d;
  end

  // Read mux
  logic [15:0] ctrl_view;
  always_comb begin
    ctrl_view        = ctrl_q;
    ctrl_view[B_NE]  = !f_empty;
    ctrl_view[B_OVF] = ovf_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL, OFS_CLR, OFS_SET, OFS_INV: bus_rdata = {{(TW-16){1'b0}}, ctrl_view};
      OFS_BUF:  bus_rdata = f_empty ? '0 : f_head;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/esu_checker.sv
module esu_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] fill,
  input logic             ovf,
  input logic             irq
);
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> !$past(on));

  assert_pulse_only_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (on && mode == 3'd7) |=> (fill <= $past(fill)));

  assert_off_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (fill == '0));

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !irq);
endmodule

bind edge_stamp_unit esu_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk  (clk),
  .rst_n(rst_ni),
  .on   (ctrl_q[15]),
  .mode (ctrl_q[2:0]),
  .fill (fill_cnt),
  .ovf  (ovf_q),
  .irq  (irq)
);

// File: tb/edge_stamp_unit_tb_top.sv
module edge_stamp_unit_tb_top;
  localparam logic [4:0]  A_CTRL = 5'h00, A_CLR = 5'h04, A_SET = 5'h08, A_INV = 5'h0C, A_BUF = 5'h10;
  localparam logic [31:0] TB_XOR = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n, bus_wr, bus_rd, pin_in, idle_req, dbg_halt;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [31:0] bus_rdata, tmr_a, tmr_b;
  logic        irq;

  int          n_chk = 0;
  int          n_bad = 0;
  int          irq_cnt = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  edge_stamp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .tmr_a(tmr_a),
    .tmr_b(tmr_b), .idle_req(idle_req), .dbg_halt(dbg_halt), .irq(irq)
  );

  always @(negedge clk) if (irq === 1'b1) irq_cnt++;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic edge_to(input logic lvl, input logic [31:0] ts);
    @(negedge clk);
    tmr_a = ts; tmr_b = ts ^ TB_XOR; pin_in = lvl;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] ts_r, input logic [31:0] ts_f);
    edge_to(1'b1, ts_r);
    edge_to(1'b0, ts_f);
  endtask

  // Monitor side of the scoreboard: pop each stored stamp and compare.
  task automatic drain(input string req);
    logic [31:0] c, v;
    for (int guard = 0; guard < 8; guard++) begin
      brd(A_CTRL, c);
      if (c[3] !== 1'b1) break;
      brd(A_BUF, v);
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s actual=%h expected=<none>", req, v);
      end else begin
        chk(req, v, exp_q.pop_front());
      end
    end
    chk({req, " leftover"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 1'b0; idle_req = 1'b0; dbg_halt = 1'b0; tmr_a = '0; tmr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    brd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    brd(A_BUF, d);  chk("R1 buf", d, 32'h0);

    // R2 aliases and writable mask
    bwr(A_CTRL, 16'hFFFF); brd(A_CTRL, d); chk("R2 write", d, 32'hE3E7);
    bwr(A_CLR, 16'hE000);  brd(A_CTRL, d); chk("R2 clear", d, 32'h03E7);
    bwr(A_SET, 16'h8000);  brd(A_CTRL, d); chk("R2 set", d, 32'h83E7);
    bwr(A_INV, 16'h0007);  brd(A_CTRL, d); chk("R2 invert", d, 32'h83E0);
    bwr(A_CTRL, 16'h0000);

    // R4 edge selection
    bwr(A_CTRL, 16'h8001); pulse(32'd100, 32'd101);
    exp_q.push_back(32'd100); exp_q.push_back(32'd101); drain("R4 any");
    bwr(A_CTRL, 16'h8003); pulse(32'd110, 32'd111);
    exp_q.push_back(32'd110); drain("R4 rise");
    bwr(A_CTRL, 16'h8002); pulse(32'd120, 32'd121);
    exp_q.push_back(32'd121); drain("R4 fall");

    // R11 disabled / mode 0
    bwr(A_CTRL, 16'h8000); pulse(32'd130, 32'd131); drain("R11 mode0");
    bwr(A_CTRL, 16'h0003); pulse(32'd132, 32'd133); drain("R11 off");

    // R5 prescale
    bwr(A_CTRL, 16'h8004);
    for (int i = 1; i <= 4; i++) pulse(32'd200 + i, 32'd300 + i);
    exp_q.push_back(32'd204); drain("R5 div4");
    bwr(A_CTRL, 16'h8005);
    for (int i = 1; i <= 16; i++) pulse(32'd400 + i, 32'd450 + i);
    exp_q.push_back(32'd416); drain("R5 div16");

    // R13 restart on mode change
    bwr(A_CTRL, 16'h8004);
    pulse(32'd500, 32'd501); pulse(32'd502, 32'd503);
    bwr(A_CTRL, 16'h8005); bwr(A_CTRL, 16'h8004);
    for (int i = 0; i < 4; i++) pulse(32'd510 + i, 32'd520 + i);
    exp_q.push_back(32'd513); drain("R13 restart");

    // R6 trigger mode
    bwr(A_CTRL, 16'h0000); bwr(A_CTRL, 16'h8006);
    pulse(32'd600, 32'd601); pulse(32'd602, 32'd603);
    exp_q.push_back(32'd601); exp_q.push_back(32'd602); exp_q.push_back(32'd603);
    drain("R6 first falling");
    bwr(A_CTRL, 16'h0000); bwr(A_CTRL, 16'h8206);
    pulse(32'd610, 32'd611);
    exp_q.push_back(32'd610); exp_q.push_back(32'd611); drain("R6 first rising");

    // R7 interrupt-only
    bwr(A_CTRL, 16'h0000); irq_cnt = 0; bwr(A_CTRL, 16'h8007);
    pulse(32'd620, 32'd621); pulse(32'd622, 32'd623);
    repeat (2) @(negedge clk);
    chk("R7 irq count", irq_cnt, 2);
    brd(A_CTRL, d); chk("R7 nothing stored", d, 32'h8007);

    // R8 interrupt rate
    bwr(A_CTRL, 16'h0000); bwr(A_CTRL, 16'h8043); irq_cnt = 0;
    pulse(32'd700, 32'd0); pulse(32'd701, 32'd0);
    chk("R8 no irq before 3rd", irq_cnt, 0);
    pulse(32'd702, 32'd0);
    chk("R8 irq on 3rd", irq_cnt, 1);
    exp_q.push_back(32'd700); exp_q.push_back(32'd701); exp_q.push_back(32'd702);
    drain("R8 data");
    for (int i = 0; i < 3; i++) pulse(32'd710 + i, 32'd0);
    chk("R8 irq on 6th", irq_cnt, 2);
    for (int i = 0; i < 3; i++) exp_q.push_back(32'd710 + i);
    drain("R8 data2");
    bwr(A_CTRL, 16'h0000); bwr(A_CTRL, 16'h8003); irq_cnt = 0;
    pulse(32'd720, 32'd0); pulse(32'd721, 32'd0);
    chk("R8 every capture", irq_cnt, 2);
    exp_q.push_back(32'd720); exp_q.push_back(32'd721); drain("R8 data3");

    // R9 timer select and width
    pulse(32'h1234_5678, 32'h0);
    exp_q.push_back(32'h0000_5678); drain("R9 narrow");
    bwr(A_CTRL, 16'h8183); pulse(32'hCAFE_0001, 32'h0);
    exp_q.push_back(32'h90A4_0001); drain("R9 timer b wide");
    bwr(A_CTRL, 16'h8103); pulse(32'hBEEF_0002, 32'h0);
    exp_q.push_back(32'hBEEF_0002); drain("R9 timer a wide");

    // R10 idle stop and debug freeze
    bwr(A_CTRL, 16'hA003); idle_req = 1'b1;
    pulse(32'd800, 32'd0); drain("R10 idle stop");
    idle_req = 1'b0; pulse(32'd801, 32'd0);
    exp_q.push_back(32'd801); drain("R10 idle released");
    bwr(A_CTRL, 16'hC003); dbg_halt = 1'b1;
    pulse(32'd810, 32'd0); drain("R10 freeze");
    dbg_halt = 1'b0; pulse(32'd811, 32'd0);
    exp_q.push_back(32'd811); drain("R10 freeze released");
    bwr(A_CTRL, 16'h8003); dbg_halt = 1'b1; idle_req = 1'b1;
    pulse(32'd820, 32'd0);
    exp_q.push_back(32'd820); drain("R10 bits clear");
    dbg_halt = 1'b0; idle_req = 1'b0;

    // R3 / R12 overflow, order and flags
    bwr(A_CTRL, 16'h0000); bwr(A_CTRL, 16'h8001);
    pulse(32'd1, 32'd2); pulse(32'd3, 32'd4); edge_to(1'b1, 32'd5);
    brd(A_CTRL, d); chk("R3 overflow and not-empty", d, 32'h8019);
    for (int i = 1; i <= 4; i++) exp_q.push_back(i);
    drain("R12 oldest first");
    brd(A_CTRL, d); chk("R12 empty flag clear", d, 32'h8011);
    bwr(A_CTRL, 16'h0000); edge_to(1'b0, 32'd0);
    brd(A_CTRL, d); chk("R3 disable clears ovf", d, 32'h0);
    bwr(A_CTRL, 16'h8001); pulse(32'd900, 32'd901);
    bwr(A_CLR, 16'h8000);
    brd(A_CTRL, d); chk("R3 disable flushes", d, 32'h0001);
    brd(A_BUF, d);  chk("R3 flushed buffer", d, 32'h0);

    report();
    $finish;
  end
endmodule